// File: doc/BRIEF.md
# Dual Maskable Time Alarm Unit

This block watches a running BCD time and calendar and raises two independent alarm flags when the time agrees with two programmed alarm settings. The first alarm compares seconds, minutes, hours and a day-or-date field. The second alarm compares minutes, hours and a day-or-date field, and is only ever evaluated at the top of a minute. Every alarm register byte carries a mask bit in bit 7. A set mask removes that field from the comparison, so an exact once-per-month match can be relaxed into a periodic match (every second, minute, hour, day or date).

A single active-low output line is shared between two uses. In interrupt mode it is pulled low while any alarm flag whose enable is set is pending, and it is released once the host clears the flag. In square-wave mode it carries a clock divided down from a strobe that marks every edge of a 32.768 kHz oscillator. Bus decoding lives elsewhere: register contents, the time, the one-second strobe and the oscillator-edge strobe arrive as plain inputs.

A four-state evaluation sequencer runs once per one-second strobe. In `SEQ_WAIT` it idles until `sec_tick` is sampled high, then moves to `SEQ_SNAP`. `SEQ_SNAP` captures the time inputs into a snapshot register and always moves to `SEQ_ALM1`. `SEQ_ALM1` sets the first flag if its comparison hits and always moves to `SEQ_ALM2`. `SEQ_ALM2` sets the second flag if its comparison hits and always returns to `SEQ_WAIT`. A three-state output selector picks `OUT_WAVE` when interrupt mode is off. With interrupt mode on, it picks `OUT_ALERT` when an enabled flag is pending and `OUT_QUIET` otherwise. It re-evaluates this choice on every clock.

Top module: `dual_alarm_unit`

## Requirements
- R1: After reset both alarm flags read 0 and `irq_n` reads 1.
- R2: Alarm 1 hits when every unmasked field agrees. A field is unmasked when bit 7 of its register is 0. Seconds, minutes and hours compare bits 6:0 of the register against the 7-bit time input, so the hour comparison includes the 12/24 select (bit 6) and the AM/PM or tens bit (bit 5). With all four masks set, alarm 1 hits on every evaluation.
- R3: Alarm 2 follows the same rules over minutes, hours and day/date. It can only hit when `cur_sec` equals 0, even with all its masks set.
- R4: In a day/date register, bit 6 selects the comparison. When bit 6 is 1, bits 3:0 are compared with `cur_day`. When bit 6 is 0, bits 5:0 are compared with `cur_date`.
- R5: Evaluation happens only after `sec_tick` is sampled high in `SEQ_WAIT`. Call the clock edge that samples the tick edge k. Alarm 1 can set its flag at edge k+2 and alarm 2 at edge k+3. No flag changes without a tick.
- R6: A flag stays set until its clear pulse (`a1_clr` or `a2_clr`) is sampled, and it then reads 0 after that edge. If a set and a clear fall on the same edge, the set wins.
- R7: With `int_mode` = 1, `irq_n` goes low one cycle after a flag is set while its enable (`a1_en` or `a2_en`) is 1. It goes high again one cycle after no enabled flag remains. A flag whose enable is 0 leaves `irq_n` high.
- R8: With `int_mode` = 0, `irq_n` shows a bit of a 16-bit count of sampled `osc_edge` strobes, one cycle late. `rate_sel` selects the bit as follows: 00 picks bit 15 (1 Hz), 01 picks bit 3 (4.096 kHz), 10 picks bit 2 (8.192 kHz) and 11 picks bit 0 (32.768 kHz).
- R9: In square-wave mode the flags are still set by matches, and a pending flag has no effect on `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_edge | input | 1 | Strobe, one per edge of the 32.768 kHz oscillator |
| sec_tick | input | 1 | One-second strobe that starts an evaluation |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD with 12/24 and AM/PM bits |
| cur_day | input | 4 | Current day of week |
| cur_date | input | 6 | Current date of month, BCD |
| a1_sec | input | 8 | Alarm 1 seconds, bit 7 mask |
| a1_min | input | 8 | Alarm 1 minutes, bit 7 mask |
| a1_hour | input | 8 | Alarm 1 hours, bit 7 mask |
| a1_dd | input | 8 | Alarm 1 day/date, bit 7 mask, bit 6 day select |
| a2_min | input | 8 | Alarm 2 minutes, bit 7 mask |
| a2_hour | input | 8 | Alarm 2 hours, bit 7 mask |
| a2_dd | input | 8 | Alarm 2 day/date, bit 7 mask, bit 6 day select |
| int_mode | input | 1 | 1 selects interrupt, 0 selects square wave |
| rate_sel | input | 2 | Square-wave rate select |
| a1_en | input | 1 | Alarm 1 interrupt enable |
| a2_en | input | 1 | Alarm 2 interrupt enable |
| a1_clr | input | 1 | Clear pulse for alarm 1 flag |
| a2_clr | input | 1 | Clear pulse for alarm 2 flag |
| a1_flag | output | 1 | Alarm 1 flag |
| a2_flag | output | 1 | Alarm 2 flag |
| irq_n | output | 1 | Shared active-low interrupt or square-wave output |

## Verification
The bench builds the block with its default 16-bit divider. This keeps the 1 Hz tap reachable: the bench drives one strobe per clock, so 32,768 strobes carry the count past the rollover of its top bit in a few tens of thousands of cycles. It also lets the faster taps be checked after short bursts of random length. Random times and alarm settings copy the current field about half the time, which makes hits, misses and masked fields all common. Alarm 2 evaluations fall on second zero roughly a third of the time.

// File: rtl/alarm_pkg.sv
`timescale 1ns/1ps
package alarm_pkg;
    localparam int NUM_ALARMS = 2;
    localparam int REG_W      = 8;
    localparam int SEC_W      = 7;
    localparam int MIN_W      = 7;
    localparam int HR_W       = 7;
    localparam int DOW_W      = 4;
    localparam int DOM_W      = 6;
    localparam int MASK_BIT   = 7;
    localparam int SEL_BIT    = 6;
    localparam int TAP_4K     = 3;
    localparam int TAP_8K     = 2;
    localparam int TAP_32K    = 0;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hour;
        logic [DOW_W-1:0] dow;
        logic [DOM_W-1:0] dom;
    } tod_t;

    typedef enum logic [1:0] {
        SEQ_WAIT = 2'd0,
        SEQ_SNAP = 2'd1,
        SEQ_ALM1 = 2'd2,
        SEQ_ALM2 = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        OUT_QUIET = 2'd0,
        OUT_ALERT = 2'd1,
        OUT_WAVE  = 2'd2
    } out_state_t;
endpackage

// File: rtl/alarm_match.sv
`timescale 1ns/1ps
module alarm_match
    import alarm_pkg::*;
(
    input  tod_t             now,
    input  logic [REG_W-1:0] a_sec,
    input  logic [REG_W-1:0] a_min,
    input  logic [REG_W-1:0] a_hour,
    input  logic [REG_W-1:0] a_dd,
    output logic             hit
);
    logic sec_ok, min_ok, hour_ok, dd_ok;

    always_comb begin
        sec_ok  = a_sec[MASK_BIT]  | (a_sec[SEC_W-1:0] == now.sec);
        min_ok  = a_min[MASK_BIT]  | (a_min[MIN_W-1:0] == now.min);
        hour_ok = a_hour[MASK_BIT] | (a_hour[HR_W-1:0] == now.hour);
        if (a_dd[MASK_BIT])
            dd_ok = 1'b1;
        else if (a_dd[SEL_BIT])
            dd_ok = (a_dd[DOW_W-1:0] == now.dow);
        else
            dd_ok = (a_dd[DOM_W-1:0] == now.dom);
        hit = sec_ok & min_ok & hour_ok & dd_ok;
    end
endmodule

// File: rtl/alarm_seq.sv
`timescale 1ns/1ps
module alarm_seq
    import alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sec_tick,
    input  logic [NUM_ALARMS-1:0] hit,
    input  logic [NUM_ALARMS-1:0] clr,
    output logic                  snap_load,
    output logic [NUM_ALARMS-1:0] flag
);
    seq_state_t seq_q, seq_d;
    logic [NUM_ALARMS-1:0] set_vec;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_WAIT: if (sec_tick) seq_d = SEQ_SNAP;
            SEQ_SNAP: seq_d = SEQ_ALM1;
            SEQ_ALM1: seq_d = SEQ_ALM2;
            SEQ_ALM2: seq_d = SEQ_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_WAIT;
        else        seq_q <= seq_d;
    end

    always_comb begin
        snap_load = 1'b0;
        set_vec   = '0;
        unique case (seq_q)
            SEQ_WAIT: ;
            SEQ_SNAP: snap_load = 1'b1;
            SEQ_ALM1: set_vec[0] = hit[0];
            SEQ_ALM2: set_vec[1] = hit[1];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= '0;
        else        flag <= set_vec | (flag & ~clr);
    end
endmodule

// File: rtl/wave_div.sv
`timescale 1ns/1ps
module wave_div
    import alarm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_edge,
    input  logic [1:0] rate_sel,
    output logic       wave
);
    localparam int TAP_1HZ = DIV_W - 1;

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (osc_edge) cnt <= cnt + 1'b1;
    end

    always_comb begin
        unique case (rate_sel)
            2'b00: wave = cnt[TAP_1HZ];
            2'b01: wave = cnt[TAP_4K];
            2'b10: wave = cnt[TAP_8K];
            2'b11: wave = cnt[TAP_32K];
        endcase
    end
endmodule

// File: rtl/line_drive.sv
`timescale 1ns/1ps
module line_drive
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic int_mode,
    input  logic pending,
    input  logic wave,
    output logic irq_n
);
    out_state_t out_q, out_d;
    logic wave_q;

    always_comb begin
        if (!int_mode)    out_d = OUT_WAVE;
        else if (pending) out_d = OUT_ALERT;
        else              out_d = OUT_QUIET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= OUT_QUIET;
            wave_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            wave_q <= wave;
        end
    end

    always_comb begin
        unique case (out_q)
            OUT_WAVE:  irq_n = wave_q;
            OUT_ALERT: irq_n = 1'b0;
            OUT_QUIET: irq_n = 1'b1;
            default:   irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/dual_alarm_unit.sv
`timescale 1ns/1ps
module dual_alarm_unit
    import alarm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_edge,
    input  logic             sec_tick,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [MIN_W-1:0] cur_min,
    input  logic [HR_W-1:0]  cur_hour,
    input  logic [DOW_W-1:0] cur_day,
    input  logic [DOM_W-1:0] cur_date,
    input  logic [REG_W-1:0] a1_sec,
    input  logic [REG_W-1:0] a1_min,
    input  logic [REG_W-1:0] a1_hour,
    input  logic [REG_W-1:0] a1_dd,
    input  logic [REG_W-1:0] a2_min,
    input  logic [REG_W-1:0] a2_hour,
    input  logic [REG_W-1:0] a2_dd,
    input  logic             int_mode,
    input  logic [1:0]       rate_sel,
    input  logic             a1_en,
    input  logic             a2_en,
    input  logic             a1_clr,
    input  logic             a2_clr,
    output logic             a1_flag,
    output logic             a2_flag,
    output logic             irq_n
);
    tod_t snap_q;
    logic snap_load;
    logic wave;
    logic [NUM_ALARMS-1:0] hit, flag, clr, en;
    logic [REG_W-1:0] sec_arr [NUM_ALARMS];
    logic [REG_W-1:0] min_arr [NUM_ALARMS];
    logic [REG_W-1:0] hr_arr  [NUM_ALARMS];
    logic [REG_W-1:0] dd_arr  [NUM_ALARMS];

    // alarm 2 has no seconds register: an unmasked zero forces second 00
    assign sec_arr[0] = a1_sec;
    assign sec_arr[1] = '0;
    assign min_arr[0] = a1_min;
    assign min_arr[1] = a2_min;
    assign hr_arr[0]  = a1_hour;
    assign hr_arr[1]  = a2_hour;
    assign dd_arr[0]  = a1_dd;
    assign dd_arr[1]  = a2_dd;
    assign clr        = {a2_clr, a1_clr};
    assign en         = {a2_en, a1_en};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_load) snap_q <= '{sec: cur_sec, min: cur_min, hour: cur_hour,
                                        dow: cur_day, dom: cur_date};
    end

    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_match
        alarm_match i_match (
            .now    (snap_q),
            .a_sec  (sec_arr[g]),
            .a_min  (min_arr[g]),
            .a_hour (hr_arr[g]),
            .a_dd   (dd_arr[g]),
            .hit    (hit[g])
        );
    end

    alarm_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .hit       (hit),
        .clr       (clr),
        .snap_load (snap_load),
        .flag      (flag)
    );

    wave_div #(.DIV_W(DIV_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_edge (osc_edge),
        .rate_sel (rate_sel),
        .wave     (wave)
    );

    line_drive i_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_mode (int_mode),
        .pending  (|(flag & en)),
        .wave     (wave),
        .irq_n    (irq_n)
    );

    assign a1_flag = flag[0];
    assign a2_flag = flag[1];
endmodule

// File: rtl/dual_alarm_chk.sv
`timescale 1ns/1ps
module dual_alarm_chk (
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic int_mode,
    input logic a1_en,
    input logic a2_en,
    input logic a1_clr,
    input logic a2_clr,
    input logic a1_flag,
    input logic a2_flag,
    input logic irq_n
);
    // R5
    a1_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a1_flag) |-> $past(sec_tick, 3));
    // R5
    a2_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a2_flag) |-> $past(sec_tick, 4));
    // R6
    a1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a1_clr && !$past(sec_tick, 2)) |=> $stable(a1_flag));
    // R6
    a2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a2_clr && !$past(sec_tick, 3)) |=> $stable(a2_flag));
    // R6
    a1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a1_clr && !$past(sec_tick, 2)) |=> !a1_flag);
    // R6
    a2_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a2_clr && !$past(sec_tick, 3)) |=> !a2_flag);
    // R7
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && ((a1_flag && a1_en) || (a2_flag && a2_en))) |=> !irq_n);
    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && !((a1_flag && a1_en) || (a2_flag && a2_en))) |=> irq_n);
endmodule

bind dual_alarm_unit dual_alarm_chk i_chk (.*);

// File: tb/test_dual_alarm_unit.sv
`timescale 1ns/1ps
module test_dual_alarm_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_edge = 1'b0, sec_tick = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [3:0] cur_day = '0;
    logic [5:0] cur_date = '0;
    logic [7:0] a1_sec = '0, a1_min = '0, a1_hour = '0, a1_dd = '0;
    logic [7:0] a2_min = '0, a2_hour = '0, a2_dd = '0;
    logic int_mode = 1'b1;
    logic [1:0] rate_sel = '0;
    logic a1_en = 1'b0, a2_en = 1'b0, a1_clr = 1'b0, a2_clr = 1'b0;
    logic a1_flag, a2_flag, irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [15:0] edges = '0;

    always #5 clk = ~clk;

    dual_alarm_unit i_dual_alarm_unit (.*);

    task automatic check(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic bit fld_ok(input logic [7:0] a, input logic [6:0] v);
        return a[7] || (a[6:0] == v);
    endfunction

    function automatic bit dd_ok(input logic [7:0] a, input logic [3:0] dw, input logic [5:0] dt);
        if (a[7]) return 1'b1;
        if (a[6]) return a[3:0] == dw;
        return a[5:0] == dt;
    endfunction

    function automatic bit exp_a1();
        return fld_ok(a1_sec, cur_sec) && fld_ok(a1_min, cur_min) &&
               fld_ok(a1_hour, cur_hour) && dd_ok(a1_dd, cur_day, cur_date);
    endfunction

    function automatic bit exp_a2();
        return (cur_sec == 7'd0) && fld_ok(a2_min, cur_min) &&
               fld_ok(a2_hour, cur_hour) && dd_ok(a2_dd, cur_day, cur_date);
    endfunction

    function automatic logic wave_bit(input logic [1:0] sel, input logic [15:0] c);
        case (sel)
            2'b00:   return c[15];
            2'b01:   return c[3];
            2'b10:   return c[2];
            default: return c[0];
        endcase
    endfunction

    function automatic logic [7:0] pick(input logic [7:0] same, input logic [7:0] rnd);
        logic [7:0] v;
        v = ($urandom % 2) ? same : rnd;
        v[7] = (($urandom % 3) == 0);
        return v;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    task automatic clear_both();
        @(negedge clk) begin a1_clr = 1'b1; a2_clr = 1'b1; end
        @(negedge clk) begin a1_clr = 1'b0; a2_clr = 1'b0; end
    endtask

    task automatic run_edges(input int n);
        @(negedge clk) osc_edge = 1'b1;
        repeat (n) @(negedge clk);
        osc_edge = 1'b0;
        edges = edges + 16'(n);
        cyc(2);
    endtask

    task automatic rand_time();
        logic [7:0] h;
        cur_sec  = (($urandom % 3) == 0) ? 7'd0 : bcd($urandom % 60)[6:0];
        cur_min  = bcd($urandom % 60)[6:0];
        if ($urandom % 2) h = bcd($urandom % 24);
        else begin
            h = bcd(1 + $urandom % 12);
            h[6] = 1'b1;
            h[5] = $urandom % 2;
        end
        cur_hour = h[6:0];
        cur_day  = 4'(1 + $urandom % 7);
        cur_date = bcd(1 + $urandom % 31)[5:0];
    endtask

    task automatic rand_alarms();
        logic [7:0] d;
        a1_sec  = pick({1'b0, cur_sec},  bcd($urandom % 60));
        a1_min  = pick({1'b0, cur_min},  bcd($urandom % 60));
        a1_hour = pick({1'b0, cur_hour}, bcd($urandom % 24));
        a2_min  = pick({1'b0, cur_min},  bcd($urandom % 60));
        a2_hour = pick({1'b0, cur_hour}, bcd($urandom % 24));
        d = ($urandom % 2) ? {2'b01, 2'b00, cur_day} : {2'b00, cur_date};
        a1_dd = pick(d, bcd(1 + $urandom % 31) | {1'b0, 1'($urandom % 2), 6'd0});
        d = ($urandom % 2) ? {2'b01, 2'b00, cur_day} : {2'b00, cur_date};
        a2_dd = pick(d, bcd(1 + $urandom % 31) | {1'b0, 1'($urandom % 2), 6'd0});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        check(a1_flag, 1'b0, "R1 a1_flag after reset");
        check(a2_flag, 1'b0, "R1 a2_flag after reset");
        check(irq_n, 1'b1, "R1 irq_n after reset");

        // R5 no tick, no flag; then exact set latency (R2 all masks, R3 at second 00)
        a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
        a2_min = 8'h80; a2_hour = 8'h80; a2_dd = 8'h80;
        cur_sec = 7'h00;
        cyc(6);
        check(a1_flag, 1'b0, "R5 no tick keeps a1 clear");
        check(a2_flag, 1'b0, "R5 no tick keeps a2 clear");
        tick();
        @(negedge clk);
        check(a1_flag, 1'b0, "R5 a1 before edge k+2");
        @(negedge clk);
        check(a1_flag, 1'b1, "R5 R2 a1 at edge k+2 all masked");
        check(a2_flag, 1'b0, "R5 a2 before edge k+3");
        @(negedge clk);
        check(a2_flag, 1'b1, "R5 R3 a2 at edge k+3 all masked");
        cyc(2);
        check(irq_n, 1'b1, "R7 disabled flags leave line high");
        clear_both();
        check(a1_flag, 1'b0, "R6 clear a1");
        check(a2_flag, 1'b0, "R6 clear a2");

        // R3 alarm 2 fully masked but seconds nonzero
        cur_sec = 7'h05;
        tick(); cyc(6);
        check(a2_flag, 1'b0, "R3 a2 silent off second 00");
        check(a1_flag, 1'b1, "R2 a1 every second");
        clear_both();

        // R4 day versus date select
        cur_day = 4'd3; cur_date = 6'h15;
        a1_dd = 8'h43;
        tick(); cyc(6);
        check(a1_flag, 1'b1, "R4 day select matches weekday");
        clear_both();
        a1_dd = 8'h03;
        tick(); cyc(6);
        check(a1_flag, 1'b0, "R4 date select ignores weekday");
        a1_dd = 8'h15;
        tick(); cyc(6);
        check(a1_flag, 1'b1, "R4 date select matches date");
        clear_both();

        // R2 hour bit 6 (12/24) is compared
        a1_dd = 8'h80; cur_hour = 7'h11; a1_hour = 8'h51;
        tick(); cyc(6);
        check(a1_flag, 1'b0, "R2 12h alarm vs 24h time");
        a1_hour = 8'h80;

        // R6 set wins over a same-edge clear, then sticky
        a1_en = 1'b1;
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        @(negedge clk) a1_clr = 1'b1;
        @(negedge clk) a1_clr = 1'b0;
        check(a1_flag, 1'b1, "R6 set beats clear");
        cyc(8);
        check(a1_flag, 1'b1, "R6 flag sticky");
        check(irq_n, 1'b0, "R7 enabled flag pulls line low");
        clear_both();
        @(negedge clk);
        check(irq_n, 1'b1, "R7 release after clear");

        // Random mix (R2 R3 R4 R7 R6)
        for (int i = 0; i < 80; i++) begin
            bit e1, e2;
            rand_time();
            rand_alarms();
            a1_en = $urandom % 2;
            a2_en = $urandom % 2;
            e1 = exp_a1();
            e2 = exp_a2();
            tick(); cyc(6);
            check(a1_flag, e1, "R2 random a1");
            check(a2_flag, e2, "R3 R4 random a2");
            check(irq_n, !((e1 && a1_en) || (e2 && a2_en)), "R7 random line");
            clear_both();
            @(negedge clk);
            check(irq_n, 1'b1, "R6 R7 cleared line high");
        end

        // R9 flags still set in square-wave mode, line shows wave
        a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
        a1_en = 1'b1; int_mode = 1'b0; rate_sel = 2'b11;
        tick(); cyc(6);
        check(a1_flag, 1'b1, "R9 flag set in wave mode");
        check(irq_n, wave_bit(rate_sel, edges), "R9 line follows wave");
        run_edges(1);
        check(irq_n, wave_bit(rate_sel, edges), "R9 line follows wave after edge");
        clear_both();

        // R8 each rate
        for (int s = 0; s < 4; s++) begin
            rate_sel = 2'(s);
            for (int k = 0; k < 4; k++) begin
                run_edges(1 + $urandom % 20);
                check(irq_n, wave_bit(rate_sel, edges), "R8 wave tap");
            end
        end
        rate_sel = 2'b00;
        cyc(2);
        check(irq_n, wave_bit(2'b00, edges), "R8 1 Hz low before rollover");
        run_edges(32768 - int'(edges));
        check(irq_n, 1'b1, "R8 1 Hz high at bit 15");
        run_edges(5);
        check(irq_n, wave_bit(2'b00, edges), "R8 1 Hz holds");

        // R7 back to interrupt mode with nothing pending
        int_mode = 1'b1;
        cyc(2);
        check(irq_n, 1'b1, "R7 interrupt mode idle high");

        done = 1;
        summary();
        $finish;
    end
endmodule